// File: doc/BRIEF.md
# USB Bulk/Interrupt OUT Endpoint Receiver

This block is the receive half of a single USB OUT endpoint for bulk and interrupt traffic. It sits behind a packet layer that has already decoded tokens and checked CRC. From that layer it sees a strobe marking the start of an OUT transaction, together with the data PID parity of the packet. It then sees payload bytes qualified by a valid signal, and finally an end-of-packet strobe carrying a CRC-good flag. Payload bytes go into a small endpoint FIFO while a counter tallies every byte the host sent. At the end of the packet the block chooses the handshake and, for an accepted packet, raises a sticky receive-done flag and an optional interrupt.

Firmware reads the received length as two byte-wide count outputs and pops the payload one byte per strobe. It then clears the flag, which also empties the FIFO and zeroes the count. The endpoint refuses new data with NAK until the flag is cleared. The same receive path serves both bulk and interrupt endpoints. The data toggle is tracked, so a retransmitted duplicate is acknowledged but its data is dropped.

Top module: `usb_out_ep_rx`

## Requirements
- R1: While `ep_enable` is low, OUT packets produce no handshake, store no data and leave `rx_done` unchanged. The expected toggle returns to DATA0.
- R2: The level of `xfer_is_intr` has no effect on any output.
- R3: A packet is accepted when the endpoint is enabled, the flag is clear, the data PID matches the expected toggle and the CRC is good. An accepted packet sets `rx_done`, and `irq` equals `rx_done` AND `irq_en`.
- R4: After acceptance, {`cnt_hi`,`cnt_lo`} equals the number of bytes the host sent. `cnt_lo` holds bits 7:0 and `cnt_hi` holds bits 15:8.
- R5: A zero-length packet is accepted. The flag sets, both count bytes read 0 and `fifo_empty` stays high.
- R6: While `rx_done` is set, a good-CRC OUT packet is answered with NAK. Its bytes are neither stored nor counted.
- R7: A `fw_clear` pulse clears `rx_done`, zeroes the count and empties the FIFO. The next matching packet is then ACKed.
- R8: Bytes beyond FIFO capacity are dropped. The packet is still ACKed, and the count reports every byte sent.
- R9: The expected data PID starts at DATA0 and flips after each accepted packet. A NAKed packet does not flip it.
- R10: A packet ending with a bad CRC gets no handshake. It leaves the flag and the count unchanged and stores nothing.
- R11: A good-CRC packet whose PID does not match the expected toggle is ACKed. Its data is discarded, and the flag and toggle are unchanged.
- R12: `fw_data` shows the oldest stored byte. Each `fw_pop` strobe advances by one byte, in arrival order. A pop on an empty FIFO has no effect.
- R13: The handshake appears as a one-cycle `hs_valid` pulse in the cycle after `rx_eop`, with `hs_code` 2'b01 for ACK and 2'b10 for NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_enable | input | 1 | Endpoint enabled and configured |
| xfer_is_intr | input | 1 | Transfer type, 1 for interrupt, 0 for bulk (no effect) |
| tok_out | input | 1 | Start of an OUT transaction to this endpoint |
| pid_data1 | input | 1 | Data PID of the packet, 1 for DATA1, sampled with `tok_out` |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_eop | input | 1 | End of data packet |
| rx_crc_ok | input | 1 | CRC result, sampled with `rx_eop` |
| hs_valid | output | 1 | Handshake request pulse |
| hs_code | output | 2 | 2'b01 ACK, 2'b10 NAK |
| irq_en | input | 1 | Interrupt enable for the receive flag |
| rx_done | output | 1 | Sticky receive-done flag |
| irq | output | 1 | Interrupt request |
| cnt_lo | output | 8 | Received byte count, low byte |
| cnt_hi | output | 8 | Received byte count, high byte |
| fw_pop | input | 1 | Firmware FIFO read strobe |
| fw_clear | input | 1 | Firmware clears the receive flag |
| fw_data | output | 8 | Byte at the FIFO head |
| fifo_empty | output | 1 | No stored byte left to read |

## Verification
The bench builds the block with an 8-byte FIFO, a 16-bit counter and a combinational interrupt. With the small FIFO, packets of up to 20 bytes cover both a partly filled FIFO and overflow, and the count can be checked past capacity. Random packets mix PID mismatches, bad CRCs, disabled periods and flags that are left set. This reaches the NAK, duplicate and rollback paths many times. Directed cases pin down zero-length packets, exact-capacity packets and pops on an empty FIFO.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;

   typedef enum logic [1:0] {
      HS_NONE = 2'b00,
      HS_ACK  = 2'b01,
      HS_NAK  = 2'b10
   } hs_code_e;

   typedef enum logic [1:0] {
      PK_IDLE,
      PK_TAKE,
      PK_NAK,
      PK_DUP
   } pkt_mode_e;

endpackage

// File: rtl/ep_rx_fifo.sv
module ep_rx_fifo #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              rollback,
   input  logic              clr,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ep_rx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, wr_base, rd_ptr;
   logic [PW-1:0]     level;

   assign level   = wr_ptr - rd_ptr;
   assign full    = (level == PW'(DEPTH));
   assign empty   = (rd_ptr == wr_base);
   assign rd_data = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         wr_base <= '0;
         rd_ptr  <= '0;
      end else if (clr) begin
         wr_ptr  <= '0;
         wr_base <= '0;
         rd_ptr  <= '0;
      end else begin
         if (rollback) wr_ptr <= wr_base;
         else if (wr_en && !full) wr_ptr <= wr_ptr + 1'b1;
         if (commit) wr_base <= wr_ptr;
         if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= PW'(DEPTH));

   p_pop_empty_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !clr) |=> $stable(rd_ptr));

   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

endmodule

// File: rtl/ep_rx_ctrl.sv
module ep_rx_ctrl
   import usb_out_ep_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_enable,
   input  logic             type_seen,
   input  logic             tok_out,
   input  logic             pid_data1,
   input  logic             rx_valid,
   input  logic             rx_eop,
   input  logic             rx_crc_ok,
   input  logic             fw_clear,
   input  logic             fifo_full,
   output logic             wr_en,
   output logic             commit,
   output logic             rollback,
   output logic             fifo_clr,
   output logic             rx_done,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hs_valid,
   output logic [1:0]       hs_code
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
         $error("ep_rx_ctrl: CNT_W must lie in 9..16");
      end
   endgenerate

   pkt_mode_e        mode;
   logic [CNT_W-1:0] pkt_cnt;
   logic             exp_tog;
   logic             start, end_pkt, take_byte;

   assign start     = tok_out && ep_enable && type_seen;
   assign end_pkt   = ep_enable && rx_eop && (mode != PK_IDLE);
   assign take_byte = ep_enable && (mode == PK_TAKE) && rx_valid && !rx_eop;
   assign wr_en     = take_byte && !fifo_full;
   assign commit    = end_pkt && (mode == PK_TAKE) && rx_crc_ok;
   assign rollback  = (mode == PK_TAKE) && (!ep_enable || (rx_eop && !rx_crc_ok));
   assign fifo_clr  = fw_clear && !commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= PK_IDLE;
         pkt_cnt  <= '0;
         exp_tog  <= 1'b0;
         rx_done  <= 1'b0;
         cnt_q    <= '0;
         hs_valid <= 1'b0;
         hs_code  <= HS_NONE;
      end else begin
         if (!ep_enable) mode <= PK_IDLE;
         else if (start) begin
            if (rx_done) mode <= PK_NAK;
            else if (pid_data1 != exp_tog) mode <= PK_DUP;
            else mode <= PK_TAKE;
         end else if (rx_eop) mode <= PK_IDLE;

         if (start) pkt_cnt <= '0;
         else if (take_byte && pkt_cnt != CNT_MAX) pkt_cnt <= pkt_cnt + 1'b1;

         hs_valid <= end_pkt && rx_crc_ok;
         if (end_pkt && rx_crc_ok) hs_code <= (mode == PK_NAK) ? HS_NAK : HS_ACK;
         else hs_code <= HS_NONE;

         if (commit) begin
            rx_done <= 1'b1;
            cnt_q   <= pkt_cnt;
         end else if (fw_clear) begin
            rx_done <= 1'b0;
            cnt_q   <= '0;
         end

         if (!ep_enable) exp_tog <= 1'b0;
         else if (commit) exp_tog <= ~exp_tog;
      end
   end

   p_flag_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> (hs_valid && hs_code == HS_ACK));

   p_nak_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == HS_NAK && !$past(fw_clear)) |-> ($stable(cnt_q) && rx_done));

   p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ep_enable |=> (!hs_valid && !$rose(rx_done)));

   p_hs_after_eop_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> $past(rx_eop));

   p_hs_code_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> (hs_code == HS_ACK || hs_code == HS_NAK));

endmodule

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx #(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = 16,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ep_enable,
   input  logic       xfer_is_intr,
   input  logic       tok_out,
   input  logic       pid_data1,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       rx_eop,
   input  logic       rx_crc_ok,
   output logic       hs_valid,
   output logic [1:0] hs_code,
   input  logic       irq_en,
   output logic       rx_done,
   output logic       irq,
   output logic [7:0] cnt_lo,
   output logic [7:0] cnt_hi,
   input  logic       fw_pop,
   input  logic       fw_clear,
   output logic [7:0] fw_data,
   output logic       fifo_empty
);
   logic             wr_en, commit, rollback, fifo_clr, fifo_full;
   logic [CNT_W-1:0] cnt_q;
   logic [15:0]      cnt_ext;
   logic             type_seen;

   // Bulk and interrupt share one path: the type is accepted either way.
   assign type_seen = xfer_is_intr | ~xfer_is_intr;

   ep_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ep_enable (ep_enable),
      .type_seen (type_seen),
      .tok_out   (tok_out),
      .pid_data1 (pid_data1),
      .rx_valid  (rx_valid),
      .rx_eop    (rx_eop),
      .rx_crc_ok (rx_crc_ok),
      .fw_clear  (fw_clear),
      .fifo_full (fifo_full),
      .wr_en     (wr_en),
      .commit    (commit),
      .rollback  (rollback),
      .fifo_clr  (fifo_clr),
      .rx_done   (rx_done),
      .cnt_q     (cnt_q),
      .hs_valid  (hs_valid),
      .hs_code   (hs_code)
   );

   ep_rx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (rx_byte),
      .commit   (commit),
      .rollback (rollback),
      .clr      (fifo_clr),
      .pop      (fw_pop),
      .rd_data  (fw_data),
      .full     (fifo_full),
      .empty    (fifo_empty)
   );

   assign cnt_ext = 16'(cnt_q);
   assign cnt_lo  = cnt_ext[7:0];
   assign cnt_hi  = cnt_ext[15:8];

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= rx_done && irq_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = rx_done && irq_en;
      end
   endgenerate

   p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (IRQ_REG ? $past(rx_done) : rx_done));

endmodule

// File: tb/usb_out_ep_rx_bench.sv
`timescale 1ns/1ps
module usb_out_ep_rx_bench;
   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ep_enable = 1'b0, xfer_is_intr = 1'b0, tok_out = 1'b0, pid_data1 = 1'b0;
   logic       rx_valid = 1'b0, rx_eop = 1'b0, rx_crc_ok = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       irq_en = 1'b0, fw_pop = 1'b0, fw_clear = 1'b0;
   logic       hs_valid, rx_done, irq, fifo_empty;
   logic [1:0] hs_code;
   logic [7:0] cnt_lo, cnt_hi, fw_data;

   int checks = 0, errors = 0;
   bit m_flag = 0, m_tog = 0;
   int m_cnt = 0, m_n = 0;
   int m_mem [DEPTH];

   always #4 clk = ~clk;

   usb_out_ep_rx #(.FIFO_DEPTH(DEPTH), .CNT_W(16), .IRQ_REG(1'b0)) u_usb_out_ep_rx (
      .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .xfer_is_intr(xfer_is_intr),
      .tok_out(tok_out), .pid_data1(pid_data1), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok), .hs_valid(hs_valid), .hs_code(hs_code),
      .irq_en(irq_en), .rx_done(rx_done), .irq(irq), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .fw_pop(fw_pop), .fw_clear(fw_clear), .fw_data(fw_data), .fifo_empty(fifo_empty));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_hs(input bit en, input bit crc, input bit flag);
      if (!en || !crc) return 0;
      return flag ? 2 : 1;
   endfunction

   task automatic check_status(input string req);
      chk(rx_done == m_flag, {req, " flag"}, rx_done, m_flag);
      chk({cnt_hi, cnt_lo} == m_cnt[15:0], {req, " count"}, {cnt_hi, cnt_lo}, m_cnt);
      chk(irq == (m_flag && irq_en), {req, " R3 irq"}, irq, m_flag && irq_en);
   endtask

   task automatic send_pkt(input bit en, input bit pid, input int n, input bit crc,
                           input bit typ, input string req);
      int hs;
      bit acc;
      int tmp [DEPTH];
      hs  = exp_hs(en, crc, m_flag);
      acc = en && crc && !m_flag && (pid == m_tog);
      @(negedge clk);
      ep_enable = en; xfer_is_intr = typ; tok_out = 1'b1; pid_data1 = pid;
      @(negedge clk);
      tok_out = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_byte  = 8'($urandom);
         if (i < DEPTH) tmp[i] = int'(rx_byte);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_eop = 1'b1; rx_crc_ok = crc;
      @(negedge clk);
      rx_eop = 1'b0; rx_crc_ok = 1'b0;
      if (!en) m_tog = 0;
      if (acc) begin
         m_flag = 1; m_cnt = n; m_n = (n < DEPTH) ? n : DEPTH; m_tog = ~m_tog;
         for (int i = 0; i < m_n; i++) m_mem[i] = tmp[i];
      end
      chk(int'(hs_valid) == (hs != 0), {req, " R13 hs_valid"}, hs_valid, hs != 0);
      if (hs != 0) chk(int'(hs_code) == hs, {req, " R13 hs_code"}, hs_code, hs);
      check_status(req);
      ep_enable = 1'b1;
      @(negedge clk);
      chk(!hs_valid, {req, " R13 pulse"}, hs_valid, 0);
   endtask

   task automatic drain_clear(input bit do_drain);
      if (do_drain) begin
         for (int i = 0; i < m_n; i++) begin
            chk(!fifo_empty, "R12 not empty", fifo_empty, 0);
            chk(int'(fw_data) == m_mem[i], "R12 byte order", fw_data, m_mem[i]);
            fw_pop = 1'b1;
            @(negedge clk);
            fw_pop = 1'b0;
         end
         chk(fifo_empty, "R12 empty after drain", fifo_empty, 1);
         fw_pop = 1'b1;
         @(negedge clk);
         fw_pop = 1'b0;
         chk(fifo_empty, "R12 pop on empty", fifo_empty, 1);
      end
      fw_clear = 1'b1;
      @(negedge clk);
      fw_clear = 1'b0;
      m_flag = 0; m_cnt = 0; m_n = 0;
      chk(fifo_empty, "R7 fifo empty after clear", fifo_empty, 1);
      check_status("R7 clear");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0123));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!hs_valid && !rx_done && !irq && fifo_empty, "reset state", rx_done, 0);
      chk({cnt_hi, cnt_lo} == 0, "R4 reset count", {cnt_hi, cnt_lo}, 0);
      ep_enable = 1'b1; irq_en = 1'b1;
      @(negedge clk);

      // R5 zero-length packet, DATA0 expected first (R9)
      send_pkt(1, 0, 0, 1, 0, "R5 zlp");
      chk(fifo_empty, "R5 fifo empty", fifo_empty, 1);
      // R6 NAK while flag set, data not counted
      send_pkt(1, 1, 5, 1, 0, "R6 nak");
      chk(fifo_empty, "R6 nothing stored", fifo_empty, 1);
      drain_clear(1);
      // R9 next expects DATA1; R4 normal packet; R2 interrupt type
      send_pkt(1, 1, 5, 1, 1, "R9 R2 data1");
      drain_clear(1);
      // R8 overflow
      send_pkt(1, 0, 12, 1, 0, "R8 overflow");
      drain_clear(1);
      // exact capacity
      send_pkt(1, 1, DEPTH, 1, 0, "R8 full");
      drain_clear(1);
      // R11 duplicate (expects DATA0, send DATA1)
      send_pkt(1, 1, 4, 1, 0, "R11 dup");
      chk(fifo_empty, "R11 discarded", fifo_empty, 1);
      // R10 bad CRC on a matching packet
      send_pkt(1, 0, 6, 0, 0, "R10 badcrc");
      chk(fifo_empty, "R10 rolled back", fifo_empty, 1);
      // R1 disabled
      send_pkt(0, 0, 3, 1, 0, "R1 disabled");
      chk(fifo_empty, "R1 nothing stored", fifo_empty, 1);
      send_pkt(1, 0, 3, 1, 1, "R1 R9 after enable");
      // R6 with flag set and irq masked
      irq_en = 1'b0;
      send_pkt(1, 1, 7, 1, 1, "R6 nak masked");
      drain_clear(1);
      irq_en = 1'b1;

      for (int k = 0; k < 60; k++) begin
         bit en, pid, crc, typ;
         int n;
         en  = ($urandom_range(9) != 0);
         pid = ($urandom_range(3) != 0) ? m_tog : ~m_tog;
         crc = ($urandom_range(9) != 0);
         typ = 1'($urandom);
         n   = $urandom_range(20);
         irq_en = 1'($urandom);
         send_pkt(en, pid, n, crc, typ, "R3 R4 random");
         if (m_flag && $urandom_range(3) != 0) drain_clear($urandom_range(4) != 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule